// File: doc/BRIEF.md
# Trace Stimulus Port Address Decoder

This block sits behind a memory-mapped stimulus window and turns each write that lands in it into a trace packet request. Every channel owns a 256-byte slice of the window. The upper address bits give the channel number. The low eight bits give the packet kind and the per-write delivery options, so software never writes a control register between packets. Options are requested by clearing address bits: the write goes to the kind's base offset with the chosen option bits forced to zero.

A write is turned into a request only if all of these hold: tracing is enabled globally, the channel exists, and its bit in a 32-bit enable mask is set. The same mask applies to each group of 32 channels. The payload is captured at the requested width, capped at the native width, and flag packets always carry a single byte. A write to an offset that is not a packet address produces no request and sets a sticky error flag. The request appears one clock after the write.

Top module: `stim_port_decoder`

## Requirements
- R1: A write at address A yields, one cycle later, a request whose channel is A[CH_W+7:8]; with nothing written, `req_valid` is low.
- R2: The offset o = A[7:0] needs o[2:0] = 0. o[6:5] = 00 gives kind DATA (code 0). o[6:5] = 11 with o[4] = 0 gives FLAG (code 1). o[6:5] = 11 with o[4] = 1 gives TRIGGER (code 2). Code 3 is never produced.
- R3: For every kind, o[7] = 0 requests guaranteed delivery and o[3] = 0 requests a timestamp (`req_guar`, `req_tstamp` high).
- R4: For DATA only, o[4] = 0 sets `req_mark`. FLAG and TRIGGER requests never carry the marked option.
- R5: `wr_size` codes 0, 1, 2, 3 mean 1, 2, 4, 8 bytes. The reported size is min(`wr_size`, NATIVE_LOG2). `req_data` holds the low 2^size bytes of `wr_data`, and all higher bytes are zero.
- R6: A FLAG request always reports size 0 and carries only the low byte, whatever `wr_size` is.
- R7: A write to a channel number at or above NUM_PORTS produces no request.
- R8: While `glb_en` is low, no write produces a request.
- R9: A write to channel c produces no request when `chan_mask[c mod 32]` is 0.
- R10: A valid write to an offset outside R2 produces no request and sets `dec_err` on the next cycle. `dec_err` then stays high until reset.
- R11: During and right after reset, `req_valid` and `dec_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en | input | 1 | Global trace enable |
| chan_mask | input | 32 | Per-channel enable, indexed by channel mod 32 |
| wr_valid | input | 1 | Write strobe into the stimulus window |
| wr_addr | input | CH_W+8 | Byte address relative to the window base |
| wr_size | input | 2 | Log2 of the write width in bytes |
| wr_data | input | 8<<NATIVE_LOG2 | Write data |
| req_valid | output | 1 | Packet request pulse |
| req_chan | output | CH_W | Channel of the request |
| req_kind | output | 2 | 0 data, 1 flag, 2 trigger |
| req_guar | output | 1 | Guaranteed delivery requested |
| req_tstamp | output | 1 | Timestamp requested |
| req_mark | output | 1 | Marked data packet |
| req_size | output | 2 | Log2 of the payload bytes |
| req_data | output | 8<<NATIVE_LOG2 | Payload, zero above its size |
| dec_err | output | 1 | Sticky bad-offset flag |

## Verification
The bench drives every option subset of the three kind offsets. A decoder that tests exact offsets instead of masked ones would drop the option-bearing forms. One that swapped option bit positions would report the wrong flag. Two instances with 64-bit and 32-bit native widths take the same doubleword writes, so a missing size cap shows up as an 8-byte payload on the narrow one. Flag writes wider than one byte expose a decoder that forgets to force the single byte. Channels 3 and 35 under a mask with bit 3 clear expose modulo-32 indexing mistakes. Channels 40 and 63 expose a missing range check. Misaligned and mid-family offsets expose a sticky flag that clears itself or never sets.

// File: rtl/stim_pkg.sv
package stim_pkg;

  typedef enum logic [1:0] {
    PKT_DATA = 2'd0,
    PKT_FLAG = 2'd1,
    PKT_TRIG = 2'd2
  } pkt_kind_e;

  typedef struct packed {
    logic      legal;
    pkt_kind_e kind;
    logic      guar;
    logic      tstamp;
    logic      mark;
  } off_info_t;

  // Splits an in-window offset into kind and active-low options.
  function automatic off_info_t classify(input logic [7:0] off);
    off_info_t r;
    r.legal  = (off[2:0] == 3'b000);
    r.kind   = PKT_DATA;
    r.guar   = ~off[7];
    r.tstamp = ~off[3];
    r.mark   = 1'b0;
    unique case (off[6:5])
      2'b00: begin
        r.kind = PKT_DATA;
        r.mark = ~off[4];
      end
      2'b11: r.kind = off[4] ? PKT_TRIG : PKT_FLAG;
      default: r.legal = 1'b0;
    endcase
    return r;
  endfunction

  // Caps a requested log2 width at the native one; flags are one byte.
  function automatic logic [1:0] eff_size(input logic [1:0] req,
                                          input logic [1:0] native,
                                          input pkt_kind_e  kind);
    if (kind == PKT_FLAG) return 2'd0;
    return (req > native) ? native : req;
  endfunction

endpackage

// File: rtl/stim_offset_dec.sv
module stim_offset_dec
  import stim_pkg::*;
(
  input  logic [7:0] off,
  output off_info_t  info
);
  always_comb info = classify(off);
endmodule

// File: rtl/stim_gate.sv
module stim_gate #(
  parameter int NUM_PORTS = 40,
  parameter int CH_W      = 6
) (
  input  logic            wr_valid,
  input  logic            glb_en,
  input  logic [31:0]     chan_mask,
  input  logic [CH_W-1:0] chan,
  input  logic            legal,
  output logic            accept,
  output logic            bad_off,
  output logic            out_range
);
  logic [4:0] grp_bit;

  always_comb begin
    grp_bit   = 5'(chan);
    out_range = (32'(chan) >= NUM_PORTS);
    bad_off   = wr_valid & ~legal;
    accept    = wr_valid & legal & glb_en & ~out_range & chan_mask[grp_bit];
  end
endmodule

// File: rtl/stim_payload_fmt.sv
module stim_payload_fmt
  import stim_pkg::*;
#(
  parameter int NATIVE_LOG2 = 3,
  localparam int NBYTES     = 1 << NATIVE_LOG2
) (
  input  pkt_kind_e           kind,
  input  logic [1:0]          size_in,
  input  logic [NBYTES*8-1:0] data_in,
  output logic [1:0]          size_out,
  output logic [NBYTES*8-1:0] data_out
);
  logic [NBYTES-1:0] keep;

  always_comb size_out = eff_size(size_in, 2'(NATIVE_LOG2), kind);

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign keep[i] = (i < (32'd1 << size_out));
    assign data_out[i*8 +: 8] = keep[i] ? data_in[i*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/stim_port_decoder.sv
module stim_port_decoder
  import stim_pkg::*;
#(
  parameter int NUM_PORTS   = 40,
  parameter int CH_W        = 6,
  parameter int NATIVE_LOG2 = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        glb_en,
  input  logic [31:0]                 chan_mask,
  input  logic                        wr_valid,
  input  logic [CH_W+7:0]             wr_addr,
  input  logic [1:0]                  wr_size,
  input  logic [(8<<NATIVE_LOG2)-1:0] wr_data,
  output logic                        req_valid,
  output logic [CH_W-1:0]             req_chan,
  output logic [1:0]                  req_kind,
  output logic                        req_guar,
  output logic                        req_tstamp,
  output logic                        req_mark,
  output logic [1:0]                  req_size,
  output logic [(8<<NATIVE_LOG2)-1:0] req_data,
  output logic                        dec_err
);
  localparam int DATA_W = 8 << NATIVE_LOG2;

  off_info_t         info_w;
  logic              accept_w, bad_off_w, out_range_w;
  logic [CH_W-1:0]   chan_w;
  logic [1:0]        size_w;
  logic [DATA_W-1:0] data_w;

  assign chan_w = wr_addr[CH_W+7:8];

  stim_offset_dec u_dec (
    .off  (wr_addr[7:0]),
    .info (info_w)
  );

  stim_gate #(.NUM_PORTS(NUM_PORTS), .CH_W(CH_W)) u_gate (
    .wr_valid  (wr_valid),
    .glb_en    (glb_en),
    .chan_mask (chan_mask),
    .chan      (chan_w),
    .legal     (info_w.legal),
    .accept    (accept_w),
    .bad_off   (bad_off_w),
    .out_range (out_range_w)
  );

  stim_payload_fmt #(.NATIVE_LOG2(NATIVE_LOG2)) u_fmt (
    .kind     (info_w.kind),
    .size_in  (wr_size),
    .data_in  (wr_data),
    .size_out (size_w),
    .data_out (data_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid  <= 1'b0;
      req_chan   <= '0;
      req_kind   <= PKT_DATA;
      req_guar   <= 1'b0;
      req_tstamp <= 1'b0;
      req_mark   <= 1'b0;
      req_size   <= '0;
      req_data   <= '0;
      dec_err    <= 1'b0;
    end else begin
      req_valid <= accept_w;
      dec_err   <= dec_err | bad_off_w;
      if (accept_w) begin
        req_chan   <= chan_w;
        req_kind   <= info_w.kind;
        req_guar   <= info_w.guar;
        req_tstamp <= info_w.tstamp;
        req_mark   <= info_w.mark;
        req_size   <= size_w;
        req_data   <= data_w;
      end
    end
  end

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |=> dec_err);

  // R10
  err_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_off_w |=> !req_valid);

  // R6
  flag_one_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == PKT_FLAG) |-> (req_size == 2'd0 && !req_mark));

  // R7
  chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_range_w |=> !req_valid);

  // R8
  glb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(glb_en && wr_valid));

  // R5
  size_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (32'(req_size) <= NATIVE_LOG2));

  // R2
  kind_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_kind != 2'b11));
endmodule

// File: tb/tb_stim_port_decoder.sv
module tb_stim_port_decoder;
  localparam int NP  = 40;
  localparam int CHW = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        glb_en = 1'b0;
  logic [31:0] chan_mask = '0;
  logic        wr_valid = 1'b0;
  logic [13:0] wr_addr = '0;
  logic [1:0]  wr_size = '0;
  logic [63:0] wr_data = '0;

  logic        v0, v1, g0, g1, t0, t1, m0, m1, e0, e1;
  logic [5:0]  c0, c1;
  logic [1:0]  k0, k1, s0, s1;
  logic [63:0] d0;
  logic [31:0] d1;

  always #5ns clk = ~clk;

  stim_port_decoder #(.NUM_PORTS(NP), .CH_W(CHW), .NATIVE_LOG2(3)) dut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .chan_mask(chan_mask),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
    .req_valid(v0), .req_chan(c0), .req_kind(k0), .req_guar(g0), .req_tstamp(t0),
    .req_mark(m0), .req_size(s0), .req_data(d0), .dec_err(e0));

  stim_port_decoder #(.NUM_PORTS(NP), .CH_W(CHW), .NATIVE_LOG2(2)) dut32 (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .chan_mask(chan_mask),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data[31:0]),
    .req_valid(v1), .req_chan(c1), .req_kind(k1), .req_guar(g1), .req_tstamp(t1),
    .req_mark(m1), .req_size(s1), .req_data(d1), .dec_err(e1));

  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;
  string cur_req = "R11";

  bit          ev[2], eg[2], et[2], em[2], ee[2];
  int          ec[2], ek[2], es[2];
  logic [63:0] ed[2];

  task automatic cmp(string what, int i, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s inst%0d %s actual=%0h expected=%0h t=%0t",
               cur_req, i, what, act, exp, $time);
    end
  endtask

  task automatic check_inst(int i, logic v, logic [5:0] c, logic [1:0] k, logic g,
                            logic t, logic m, logic [1:0] s, logic [63:0] d, logic e);
    cmp("valid", i, 64'(v), 64'(ev[i]));
    cmp("err", i, 64'(e), 64'(ee[i]));
    if (ev[i]) begin
      cmp("chan", i, 64'(c), 64'(ec[i]));
      cmp("kind", i, 64'(k), 64'(ek[i]));
      cmp("guar", i, 64'(g), 64'(eg[i]));
      cmp("tstamp", i, 64'(t), 64'(et[i]));
      cmp("mark", i, 64'(m), 64'(em[i]));
      cmp("size", i, 64'(s), 64'(es[i]));
      cmp("data", i, d, ed[i]);
    end
  endtask

  // Reference: kinds are recognised as subsets of their base offsets.
  task automatic predict(int i, int nat);
    int off = int'(wr_addr) % 256;
    int ch  = int'(wr_addr) / 256;
    int kind = 0;
    int nb;
    bit ok = 1;
    if ((off | 'h98) == 'h98) kind = 0;
    else if ((off | 'h88) == 'hE8) kind = 1;
    else if ((off | 'h88) == 'hF8) kind = 2;
    else ok = 0;
    if (!rst_n) begin
      ev[i] = 0; ee[i] = 0;
      return;
    end
    ev[i] = wr_valid && ok && glb_en && ch < NP && chan_mask[ch % 32];
    if (wr_valid && !ok) ee[i] = 1;
    if (ev[i]) begin
      ec[i] = ch;
      ek[i] = kind;
      eg[i] = (off & 'h80) == 0;
      et[i] = (off & 'h08) == 0;
      em[i] = (kind == 0) && ((off & 'h10) == 0);
      es[i] = (kind == 1) ? 0 : ((int'(wr_size) > nat) ? nat : int'(wr_size));
      nb = 1 << es[i];
      ed[i] = '0;
      for (int b = 0; b < nb; b++) ed[i][b*8 +: 8] = wr_data[b*8 +: 8];
    end
  endtask

  task automatic step(bit rn, bit ge, logic [31:0] mk, bit wv, int ch, int off,
                      int sz, logic [63:0] dat);
    @(negedge clk);
    check_inst(0, v0, c0, k0, g0, t0, m0, s0, d0, e0);
    check_inst(1, v1, c1, k1, g1, t1, m1, s1, {32'h0, d1}, e1);
    rst_n = rn; glb_en = ge; chan_mask = mk; wr_valid = wv;
    wr_addr = 14'((ch << 8) | off); wr_size = 2'(sz); wr_data = dat;
    predict(0, 3);
    predict(1, 2);
  endtask

  task automatic wr(int ch, int off, int sz, logic [63:0] dat);
    step(1, 1, 32'hFFFF_FFFF, 1, ch, off, sz, dat);
  endtask

  task automatic idle();
    step(1, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 64'h0);
  endtask

  localparam logic [63:0] PAT = 64'h8877_6655_4433_2211;

  initial begin
    // R11: reset state
    cur_req = "R11";
    ev = '{0, 0}; ee = '{0, 0};
    for (int n = 0; n < 3; n++) step(0, 1, 32'hFFFF_FFFF, 1, 1, 'h98, 3, PAT);
    idle();
    // R1: channel number from upper address bits
    cur_req = "R1";
    wr(0, 'h98, 2, PAT); wr(5, 'h98, 2, PAT); wr(39, 'h98, 2, PAT); idle();
    // R2: base offsets of each kind
    cur_req = "R2";
    wr(7, 'h98, 3, PAT); wr(7, 'hE8, 0, PAT); wr(7, 'hF8, 2, PAT); idle();
    // R3: active-low guaranteed and timestamp bits
    cur_req = "R3";
    wr(2, 'h18, 2, PAT); wr(2, 'h90, 2, PAT); wr(2, 'h10, 2, PAT);
    wr(2, 'h60, 0, PAT); wr(2, 'h70, 1, PAT); wr(2, 'h78, 1, PAT); idle();
    // R4: marked only on data
    cur_req = "R4";
    wr(9, 'h88, 2, PAT); wr(9, 'h00, 2, PAT); wr(9, 'hF0, 2, PAT); idle();
    // R5: sizes and cap at native width
    cur_req = "R5";
    for (int z = 0; z < 4; z++) wr(11, 'h98, z, PAT);
    wr(11, 'hF8, 3, 64'hFFFF_FFFF_FFFF_FFFF); idle();
    // R6: flag carries one byte
    cur_req = "R6";
    wr(12, 'hE8, 3, PAT); wr(12, 'h68, 2, 64'hDEAD_BEEF_CAFE_F00D); idle();
    // R7: unimplemented channels
    cur_req = "R7";
    wr(40, 'h98, 2, PAT); wr(63, 'hE8, 0, PAT); wr(39, 'h98, 2, PAT); idle();
    // R8: global enable
    cur_req = "R8";
    step(1, 0, 32'hFFFF_FFFF, 1, 3, 'h98, 2, PAT);
    step(1, 0, 32'hFFFF_FFFF, 1, 4, 'hF8, 2, PAT); idle();
    // R9: mask indexed by channel mod 32
    cur_req = "R9";
    step(1, 1, 32'hFFFF_FFF7, 1, 3, 'h98, 2, PAT);
    step(1, 1, 32'hFFFF_FFF7, 1, 35, 'h98, 2, PAT);
    step(1, 1, 32'hFFFF_FFF7, 1, 4, 'h98, 2, PAT);
    step(1, 1, 32'hFFFF_FFF7, 1, 36, 'hE8, 2, PAT); idle();
    // R10: bad offsets and sticky error
    cur_req = "R10";
    wr(1, 'h9C, 2, PAT); idle(); wr(1, 'h40, 2, PAT); wr(1, 'hA8, 2, PAT);
    wr(1, 'h98, 2, PAT); idle(); idle();
    // R2: mixed traffic
    cur_req = "R2";
    for (int n = 0; n < 400; n++) begin
      int offs[4] = '{'h98, 'hE8, 'hF8, 'h00};
      int o = offs[$urandom % 4] & ~int'($urandom % 256 & 'h98);
      step(1, ($urandom % 8) != 0, {$urandom} | 32'hF0F0_F0F0, $urandom % 4 != 0,
           $urandom % 48, o, $urandom % 4, {$urandom, $urandom});
    end
    idle(); idle();
    // R11: reset clears sticky error
    cur_req = "R11";
    step(0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 64'h0); idle(); idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2ms;
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule